// File: doc/BRIEF.md
# Asynchronous Bus Cycle Handshake Controller

This block turns the processor's microcode-level bus requests into the strobes of an asynchronous, multiplexed 16-bit address/data bus. The strobes are address strobe (sync), write/byte qualifier, data-in and data-out. It also registers the slave's reply. One master clock drives everything. A free-running two-bit counter divides each bus clock into four phases, PH1 to PH4. Every strobe flip-flop changes only on the phase that governs it.

From the strobes the block derives several signals. One stalls the processor (busy). One tells it the transfer has completed (ready). One marks a programmed transfer in progress (I/O active). It also decodes an I/O-page select from the top address bits. That select is masked during interrupt acknowledge, during memory refresh and once a data strobe is up. While data-in is asserted, the address/data output enable is dropped so the bus can be read.

Top module: `bus_handshake`

## Requirements
- R1: After reset, `phase` is one-hot and reads 4'b0001 (PH1). It advances PH1→PH2→PH3→PH4→PH1 on every clock. All strobes, `reply_q` and `busy` are low out of reset (with `dma_req` low).
- R2: `bus_sync` is set by the clock edge that ends a PH2 cycle in which `req_sync` is high.
- R3: `bus_sync` stays asserted while the registered reply is set. It clears only at the end of a PH3 cycle in which `req_sync` is low and the registered reply is clear.
- R4: `bus_wtbt` takes the value of `req_wtbt` at the end of each PH1 cycle and holds otherwise. The processor keeps `req_wtbt` high in the data phase only for a byte write.
- R5: `bus_din` takes the value of `req_din` at the end of each PH2 cycle and holds otherwise. `dal_oe` is the inverse of `bus_din`.
- R6: At the end of each PH3 cycle, `bus_dout` becomes `req_dout` AND NOT the registered reply, and holds otherwise. It therefore clears on the PH3 that follows the reply being registered.
- R7: `reply_q` samples `slave_reply` at the end of each PH1 cycle and holds otherwise.
- R8: `io_active` equals `bus_din` OR `bus_dout`. `ready` equals `reply_q` AND `io_active`.
- R9: `busy` equals `reply_q` OR `dma_req`.
- R10: `io_page` is high exactly when `addr_hi` is all ones and `iack`, `refresh` and `io_active` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_sync | input | 1 | processor address-strobe request |
| req_wtbt | input | 1 | processor write/byte request |
| req_din | input | 1 | processor data-in request |
| req_dout | input | 1 | processor data-out request |
| slave_reply | input | 1 | slave reply from the bus |
| dma_req | input | 1 | pending DMA request |
| addr_hi | input | PAGE_BITS (3) | top address bits |
| iack | input | 1 | interrupt-acknowledge cycle |
| refresh | input | 1 | memory refresh cycle |
| phase | output | 4 | one-hot current phase, bit 0 = PH1 |
| bus_sync | output | 1 | address strobe |
| bus_wtbt | output | 1 | write/byte qualifier |
| bus_din | output | 1 | data-in strobe |
| bus_dout | output | 1 | data-out strobe |
| reply_q | output | 1 | registered slave reply |
| busy | output | 1 | processor stall |
| ready | output | 1 | transfer complete to processor |
| io_active | output | 1 | programmed transfer in progress |
| io_page | output | 1 | I/O-page select |
| dal_oe | output | 1 | address/data output enable |

## Verification
Every registered strobe changes on the first clock edge after the cycle of its governing phase. That means a request can wait up to four clocks before it shows. The reply takes two flop stages to reach `bus_dout`. The bench keeps its own phase index and strobe state, updated from the inputs at each rising edge. One nanosecond after that edge it compares every output against that model, so each registered result is checked in exactly the cycle it is due. The combinational outputs `ready`, `busy`, `io_active`, `io_page` and `dal_oe` are checked in the same cycle as the inputs and state that feed them.

// File: rtl/bus_handshake.sv
module bus_handshake #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_sync,
  input  logic                 req_wtbt,
  input  logic                 req_din,
  input  logic                 req_dout,
  input  logic                 slave_reply,
  input  logic                 dma_req,
  input  logic [PAGE_BITS-1:0] addr_hi,
  input  logic                 iack,
  input  logic                 refresh,
  output logic [3:0]           phase,
  output logic                 bus_sync,
  output logic                 bus_wtbt,
  output logic                 bus_din,
  output logic                 bus_dout,
  output logic                 reply_q,
  output logic                 busy,
  output logic                 ready,
  output logic                 io_active,
  output logic                 io_page,
  output logic                 dal_oe
);
  localparam int PAGE_LSB = ADDR_W - PAGE_BITS;

  logic [1:0] ph_q;
  logic       ph1, ph2, ph3;

  assign phase = 4'b0001 << ph_q;
  assign ph1 = (ph_q == 2'd0);
  assign ph2 = (ph_q == 2'd1);
  assign ph3 = (ph_q == 2'd2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ph_q <= 2'd0;
    else        ph_q <= ph_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reply_q  <= 1'b0;
      bus_wtbt <= 1'b0;
    end else if (ph1) begin
      reply_q  <= slave_reply;
      bus_wtbt <= req_wtbt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               bus_sync <= 1'b0;
    else if (ph2 && req_sync)                 bus_sync <= 1'b1;
    else if (ph3 && !req_sync && !reply_q)    bus_sync <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   bus_din <= 1'b0;
    else if (ph2) bus_din <= req_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   bus_dout <= 1'b0;
    else if (ph3) bus_dout <= req_dout & ~reply_q;

  assign io_active = bus_din | bus_dout;
  assign ready     = reply_q & io_active;
  assign busy      = reply_q | dma_req;
  assign dal_oe    = ~bus_din;
  assign io_page   = (&addr_hi) & ~iack & ~refresh & ~io_active;

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(phase) == 1); // R1
  AST_SYNC_SET: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_sync) |-> $past(phase[1])); // R2
  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bus_sync && reply_q) |=> bus_sync); // R3
  AST_WTBT_PH1: assert property (@(posedge clk) disable iff (!rst_n) !$stable(bus_wtbt) |-> $past(phase[0])); // R4
  AST_DIN_PH2: assert property (@(posedge clk) disable iff (!rst_n) !$stable(bus_din) |-> $past(phase[1])); // R5
  AST_DOUT_PH3: assert property (@(posedge clk) disable iff (!rst_n) !$stable(bus_dout) |-> $past(phase[2])); // R6
  AST_DOUT_NO_REPLY: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_dout) |-> !$past(reply_q)); // R6
  AST_REPLY_PH1: assert property (@(posedge clk) disable iff (!rst_n) !$stable(reply_q) |-> $past(phase[0])); // R7
endmodule

// File: tb/bus_handshake_bench.sv
module bus_handshake_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_sync = 0, req_wtbt = 0, req_din = 0, req_dout = 0;
  logic slave_reply = 0, dma_req = 0, iack = 0, refresh = 0;
  logic [2:0] addr_hi = 3'b000;
  logic [3:0] phase;
  logic bus_sync, bus_wtbt, bus_din, bus_dout, reply_q;
  logic busy, ready, io_active, io_page, dal_oe;

  bus_handshake u_bus_handshake (
    .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .req_wtbt(req_wtbt),
    .req_din(req_din), .req_dout(req_dout), .slave_reply(slave_reply),
    .dma_req(dma_req), .addr_hi(addr_hi), .iack(iack), .refresh(refresh),
    .phase(phase), .bus_sync(bus_sync), .bus_wtbt(bus_wtbt), .bus_din(bus_din),
    .bus_dout(bus_dout), .reply_q(reply_q), .busy(busy), .ready(ready),
    .io_active(io_active), .io_page(io_page), .dal_oe(dal_oe)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, slave_lat = 0;
  int m_ph = 0;
  bit m_sync = 0, m_wtbt = 0, m_din = 0, m_dout = 0, m_rep = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_sync = 0; m_wtbt = 0; m_din = 0; m_dout = 0; m_rep = 0;
    end else begin
      bit old_rep;
      old_rep = m_rep;
      case (m_ph)
        0: begin m_rep = slave_reply; m_wtbt = req_wtbt; end
        1: begin m_din = req_din; if (req_sync) m_sync = 1; end
        2: begin m_dout = req_dout && !old_rep; if (!req_sync && !old_rep) m_sync = 0; end
        default: ;
      endcase
      m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic chk(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, name, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      bit m_io;
      m_io = m_din || m_dout;
      chk("R1", "phase", phase, 1 << m_ph);
      chk("R2/R3", "bus_sync", bus_sync, m_sync);
      chk("R4", "bus_wtbt", bus_wtbt, m_wtbt);
      chk("R5", "bus_din", bus_din, m_din);
      chk("R5", "dal_oe", dal_oe, !m_din);
      chk("R6", "bus_dout", bus_dout, m_dout);
      chk("R7", "reply_q", reply_q, m_rep);
      chk("R8", "io_active", io_active, m_io);
      chk("R8", "ready", ready, m_rep && m_io);
      chk("R9", "busy", busy, m_rep || dma_req);
      chk("R10", "io_page", io_page, (addr_hi == 3'b111) && !iack && !refresh && !m_io);
    end
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  int s_cnt = 0;
  always @(negedge clk) begin
    if (bus_din || bus_dout) begin
      if (s_cnt >= slave_lat) slave_reply <= 1'b1;
      s_cnt++;
    end else begin
      slave_reply <= 1'b0;
      s_cnt = 0;
    end
  end

  task automatic bus_cycle(input bit write, input bit byte_w, input logic [2:0] a, input int lat);
    slave_lat = lat;
    @(negedge clk);
    addr_hi = a; req_wtbt = write; req_sync = 1;
    repeat (5) @(negedge clk);
    req_wtbt = write && byte_w;
    if (write) req_dout = 1; else req_din = 1;
    do @(negedge clk); while (!ready);
    req_din = 0; req_dout = 0; req_wtbt = 0;
    @(negedge clk);
    req_sync = 0;
    do @(negedge clk); while (bus_sync);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    chk("R1", "reset phase", phase, 1);
    chk("R1", "reset strobes", {bus_sync, bus_wtbt, bus_din, bus_dout, reply_q, busy}, 0);
    rst_n = 1;
    repeat (8) @(negedge clk);
    bus_cycle(0, 0, 3'b111, 0);   // read, fast slave
    bus_cycle(0, 0, 3'b010, 6);   // read, slow slave
    bus_cycle(1, 0, 3'b111, 1);   // word write
    bus_cycle(1, 1, 3'b101, 9);   // byte write, slow slave
    // R10: page decode inhibits
    addr_hi = 3'b111; iack = 1; repeat (3) @(negedge clk);
    iack = 0; refresh = 1; repeat (3) @(negedge clk);
    refresh = 0; addr_hi = 3'b110; repeat (3) @(negedge clk);
    // R9: DMA request alone stalls
    dma_req = 1; repeat (5) @(negedge clk);
    bus_cycle(0, 0, 3'b111, 2);
    dma_req = 0;
    // R3: sync request dropped early while reply is still pending
    slave_lat = 0;
    req_sync = 1; repeat (5) @(negedge clk);
    req_dout = 1; do @(negedge clk); while (!reply_q);
    req_sync = 0; req_dout = 0;
    repeat (16) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule